// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from peripherals and presents them to a processor on two lines. A normal path has sixteen inputs and a fast path has eight. Each path is built from the same logic and has its own output line. Every input carries a 4-bit priority, a mask bit, and a trigger mode that selects level or rising-edge detection. Software can also raise any input by writing a register.

The processor reads a path's vector register to take the best request. The read returns the input's binary number and marks that input as in service. While the input is in service, requests of the same or lower priority on that path are held back. A write to the path's end-of-interrupt register retires the highest active priority level, which lets the held requests through again. Priority registers cannot be written while any input on the path is in service, because end-of-interrupt is matched to its source by priority.

All registers are 32 bits wide on a simple bus. Reads are combinational and take effect at the next clock edge. Address bit 7 selects the path (0 for normal, 1 for fast). Bits 6:2 select a word within the path.

Top module: `vec_intc`

## Requirements
- R1: After reset, the mask word (offset 0x00) reads all ones for every input of the path (0x0000FFFF normal, 0x000000FF fast). The in-service word (0x14) reads 0, and both lines are low.
- R2: A read of the vector word (0x18) with a valid request returns bit 8 = 1 and the winner's input number in bits 3:0. The winner is the pending, unmasked, eligible input with the numerically largest priority.
- R3: Among eligible inputs of equal priority, the lowest-numbered input wins.
- R4: A mask bit of 1 (word 0x00, bit i for input i) keeps input i from winning and from raising the line. A mask bit of 0 enables it.
- R5: A vector read that returns a valid number sets that input's in-service bit (word 0x14). Afterwards, only requests with a strictly higher priority than every in-service input can raise the line or win.
- R6: Any write to the end-of-interrupt word (0x1C) clears the in-service bit of the input at the highest active priority level. This re-enables requests at that level and below.
- R7: A vector read with nothing eligible returns 0x0000000F and changes no in-service, request or edge state.
- R8: With trigger word (0x04) bit i = 1, a rising edge on input i is latched into edge-status bit i (word 0x08). This holds for a pulse only two clock cycles long. The latched bit is cleared when that input is acknowledged. A level-mode input never sets its edge-status bit.
- R9: Writing 1 to bit i of the software-request word (0x0C) raises a request on input i. The request is visible in the request word (0x10) and is cleared when that input is acknowledged.
- R10: Priority words (0x20 + 4·i, bits 3:0) accept writes only while the path's in-service word is 0. Otherwise the write is ignored.
- R11: The fast path at base 0x80 applies the same rules to its eight inputs. It drives only the fast line, and its vector word is at 0x98.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 16 | Normal-path request inputs |
| fiq_in | input | 8 | Fast-path request inputs |
| bus_addr | input | 8 | Byte address; bit 7 selects the path |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a vector read acknowledges |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on address |
| irq_line | output | 1 | Normal-path interrupt line to the processor |
| fiq_line | output | 1 | Fast-path interrupt line to the processor |

## Verification
The bench builds the block with its defaults: sixteen normal inputs, eight fast inputs and 4-bit priorities. That gives sixteen distinct levels, so a nesting depth of two and several ties within one priority group are easy to set up. Using priority = input number / 4 puts four inputs in each group. With those values the stimulus table alone covers winning across groups, ties broken by lowest index, and masking. The eight-input fast path runs with every priority left at zero, so there its choice comes down purely to lowest index.

// File: rtl/icu_pkg.sv
package icu_pkg;
  parameter int PRIO_W  = 4;
  parameter int VEC_W   = 4;
  localparam int NUM_LVL = 1 << PRIO_W;
  localparam int VALID_BIT = 8;

  localparam logic [4:0] OFS_MASK = 5'd0;
  localparam logic [4:0] OFS_TRIG = 5'd1;
  localparam logic [4:0] OFS_EDGE = 5'd2;
  localparam logic [4:0] OFS_SWRQ = 5'd3;
  localparam logic [4:0] OFS_REQ  = 5'd4;
  localparam logic [4:0] OFS_ISR  = 5'd5;
  localparam logic [4:0] OFS_VEC  = 5'd6;
  localparam logic [4:0] OFS_EOI  = 5'd7;
  localparam logic [4:0] OFS_PRIO = 5'd8;

  // Highest set bit of the active-level set.
  function automatic logic [PRIO_W-1:0] hi_level(input logic [NUM_LVL-1:0] lv);
    hi_level = '0;
    for (int i = 0; i < NUM_LVL; i++)
      if (lv[i]) hi_level = i[PRIO_W-1:0];
  endfunction

  // A request may compete only above every active level.
  function automatic logic eligible(input logic rq, input logic msk,
                                    input logic [PRIO_W-1:0] p,
                                    input logic act_v, input logic [PRIO_W-1:0] act_l);
    eligible = rq && !msk && (!act_v || (p > act_l));
  endfunction

  // Vector word layout: valid flag at bit 8, number in bits 3:0.
  function automatic logic [31:0] vec_word(input logic v, input logic [VEC_W-1:0] num);
    vec_word = '0;
    vec_word[VALID_BIT] = v;
    vec_word[VEC_W-1:0] = v ? num : {VEC_W{1'b1}};
  endfunction
endpackage

// File: rtl/intc_capture.sv
module intc_capture
  import icu_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] in_raw,
  input  logic [N-1:0] trig,
  input  logic [N-1:0] sw_set,
  input  logic [N-1:0] edge_clr,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] req,
  output logic [N-1:0] edge_st
);
  logic [N-1:0] samp_q, prev_q, sw_q, rise;

  assign rise = samp_q & ~prev_q & trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q  <= '0;
      prev_q  <= '0;
      edge_st <= '0;
      sw_q    <= '0;
    end else begin
      samp_q  <= in_raw;
      prev_q  <= samp_q;
      edge_st <= (edge_st & ~(edge_clr | ack_clr)) | rise;
      sw_q    <= (sw_q & ~ack_clr) | sw_set;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_req
    assign req[g] = (trig[g] ? edge_st[g] : samp_q[g]) | sw_q[g];
  end

  AST_LEVEL_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_st == '0) && (trig == '0) |=> (edge_st == '0)) else $error("edge set in level mode"); // R8
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import icu_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0]        req,
  input  logic [N-1:0]        mask,
  input  logic [N*PRIO_W-1:0] prio_flat,
  input  logic                act_valid,
  input  logic [PRIO_W-1:0]   act_lvl,
  output logic                win_valid,
  output logic [VEC_W-1:0]    win_idx,
  output logic [PRIO_W-1:0]   win_prio
);
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_prio  = '0;
    for (int i = 0; i < N; i++) begin
      if (eligible(req[i], mask[i], prio_flat[i*PRIO_W +: PRIO_W], act_valid, act_lvl) &&
          (!win_valid || (prio_flat[i*PRIO_W +: PRIO_W] > win_prio))) begin
        win_valid = 1'b1;
        win_idx   = VEC_W'(i);
        win_prio  = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/intc_path.sv
module intc_path
  import icu_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] in_raw,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [4:0]   widx,
  input  logic [31:0]  wdata,
  output logic [31:0]  rdata,
  output logic         line
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]        mask_q, trig_q, isr_q;
  logic [NUM_LVL-1:0]  lvl_q;
  logic [PRIO_W-1:0]   prio_q [N];
  logic [N*PRIO_W-1:0] prio_flat;
  logic [N-1:0]        req, edge_st, sw_set, edge_clr, ack_vec;
  logic                win_valid, act_valid;
  logic [VEC_W-1:0]    win_idx;
  logic [PRIO_W-1:0]   win_prio, act_lvl;
  logic                vec_rd, ack_fire, eoi_fire, prio_wr;
  logic [4:0]          prio_sel;

  for (genvar g = 0; g < N; g++) begin : g_flat
    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
  end

  assign act_valid = |lvl_q;
  assign act_lvl   = hi_level(lvl_q);
  assign vec_rd    = rd_en && (widx == OFS_VEC);
  assign ack_fire  = vec_rd && win_valid;
  assign eoi_fire  = wr_en && (widx == OFS_EOI);
  assign sw_set    = (wr_en && widx == OFS_SWRQ) ? wdata[N-1:0] : '0;
  assign edge_clr  = (wr_en && widx == OFS_EDGE) ? wdata[N-1:0] : '0;
  assign prio_sel  = widx - OFS_PRIO;
  assign prio_wr   = wr_en && (widx >= OFS_PRIO) && (int'(prio_sel) < N) && (isr_q == '0);

  always_comb begin
    ack_vec = '0;
    if (ack_fire) ack_vec[win_idx[IDX_W-1:0]] = 1'b1;
  end

  intc_capture #(.N(N)) u_cap (
    .clk(clk), .rst_n(rst_n), .in_raw(in_raw), .trig(trig_q), .sw_set(sw_set),
    .edge_clr(edge_clr), .ack_clr(ack_vec), .req(req), .edge_st(edge_st)
  );

  intc_arbiter #(.N(N)) u_arb (
    .req(req), .mask(mask_q), .prio_flat(prio_flat), .act_valid(act_valid),
    .act_lvl(act_lvl), .win_valid(win_valid), .win_idx(win_idx), .win_prio(win_prio)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      trig_q <= '0;
    end else if (wr_en) begin
      if (widx == OFS_MASK) mask_q <= wdata[N-1:0];
      if (widx == OFS_TRIG) trig_q <= wdata[N-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) prio_q[i] <= '0;
    end else if (prio_wr) begin
      prio_q[prio_sel[IDX_W-1:0]] <= wdata[PRIO_W-1:0];
    end
  end

  // In-service tracking: one bit per input, one per priority level.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
      lvl_q <= '0;
    end else if (ack_fire) begin
      isr_q[win_idx[IDX_W-1:0]] <= 1'b1;
      lvl_q[win_prio]           <= 1'b1;
    end else if (eoi_fire && act_valid) begin
      lvl_q[act_lvl] <= 1'b0;
      for (int i = 0; i < N; i++)
        if (prio_q[i] == act_lvl) isr_q[i] <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (widx)
      OFS_MASK: rdata[N-1:0] = mask_q;
      OFS_TRIG: rdata[N-1:0] = trig_q;
      OFS_EDGE: rdata[N-1:0] = edge_st;
      OFS_REQ:  rdata[N-1:0] = req;
      OFS_ISR:  rdata[N-1:0] = isr_q;
      OFS_VEC:  rdata        = vec_word(win_valid, win_idx);
      default:
        if (widx >= OFS_PRIO && int'(prio_sel) < N)
          rdata[PRIO_W-1:0] = prio_q[prio_sel[IDX_W-1:0]];
    endcase
  end

  assign line = win_valid;

  AST_ACK_ADDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> ($countones(isr_q) == $countones($past(isr_q)) + 1)) else $error("ack"); // R5
  AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_fire && act_valid |=> ($countones(isr_q) + 1 == $countones($past(isr_q)))) else $error("eoi"); // R6
  AST_ISR_MATCHES_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(isr_q) == $countones(lvl_q)) else $error("level/isr mismatch"); // R5
  AST_EMPTY_READ_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    vec_rd && !win_valid |=> $stable(isr_q) && $stable(lvl_q)) else $error("empty read"); // R7
  AST_PRIO_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (|isr_q) |=> $stable(prio_flat)) else $error("prio changed"); // R10
  AST_MASKED_NEVER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> !mask_q[win_idx[IDX_W-1:0]]) else $error("masked winner"); // R4
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import icu_pkg::*;
#(
  parameter int N_NORM = 16,
  parameter int N_FAST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_NORM-1:0] irq_in,
  input  logic [N_FAST-1:0] fiq_in,
  input  logic [7:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_line,
  output logic              fiq_line
);
  logic        sel_fast;
  logic [4:0]  widx;
  logic [31:0] rd_norm, rd_fast;
  logic        unused_bits;

  assign sel_fast    = bus_addr[7];
  assign widx        = bus_addr[6:2];
  assign unused_bits = ^bus_addr[1:0];

  intc_path #(.N(N_NORM)) u_norm (
    .clk(clk), .rst_n(rst_n), .in_raw(irq_in),
    .wr_en(bus_wr && !sel_fast), .rd_en(bus_rd && !sel_fast),
    .widx(widx), .wdata(bus_wdata), .rdata(rd_norm), .line(irq_line)
  );

  intc_path #(.N(N_FAST)) u_fast (
    .clk(clk), .rst_n(rst_n), .in_raw(fiq_in),
    .wr_en(bus_wr && sel_fast), .rd_en(bus_rd && sel_fast),
    .widx(widx), .wdata(bus_wdata), .rdata(rd_fast), .line(fiq_line)
  );

  assign bus_rdata = sel_fast ? rd_fast : rd_norm;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd)) else $error("read and write together"); // R11
endmodule

// File: tb/test_vec_intc.sv
module test_vec_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_in = '0;
  logic [7:0]  fiq_in = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        irq_line, fiq_line;
  int          n_chk = 0, n_err = 0;
  logic [31:0] d;

  always #2.5 clk = ~clk;

  vec_intc i_vec_intc (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .fiq_in(fiq_in),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_line(irq_line), .fiq_line(fiq_line)
  );

  // Table: pattern, mask, expected vector word (priority = input / 4).
  localparam int NV = 10;
  localparam logic [15:0] T_PAT [NV] = '{16'h0001, 16'h0006, 16'h0030, 16'h8001, 16'h0F00,
                                          16'h1111, 16'h0000, 16'h00F0, 16'h8001, 16'hFFFF};
  localparam logic [15:0] T_MSK [NV] = '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000,
                                          16'h0000, 16'h0000, 16'h0010, 16'h8000, 16'hFFFF};
  localparam logic [31:0] T_EXP [NV] = '{32'h100, 32'h101, 32'h104, 32'h10F, 32'h108,
                                          32'h10C, 32'h00F, 32'h105, 32'h100, 32'h00F};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1'b1; idle(2);
    // R1 reset state
    rd(8'h00, d); check("R1 normal mask", d, 32'h0000FFFF);
    rd(8'h80, d); check("R1 fast mask", d, 32'h000000FF);
    rd(8'h14, d); check("R1 isr", d, 32'h0);
    check("R1 lines", {30'd0, irq_line, fiq_line}, 32'h0);

    for (int i = 0; i < 16; i++) wr(8'h20 + 8'(4 * i), 32'(i / 4));

    // Table walk: R2 R3 R4 R7
    for (int k = 0; k < NV; k++) begin
      wr(8'h00, {16'h0, T_MSK[k]});
      irq_in = T_PAT[k]; idle(3);
      check("R2/R4 line", {31'd0, irq_line}, {31'd0, T_EXP[k][8]});
      rd(8'h18, d); check("R2/R3/R4/R7 vector", d, T_EXP[k]);
      irq_in = '0;
      if (T_EXP[k][8]) wr(8'h1C, 32'h0);
      idle(2);
      rd(8'h14, d); check("R6/R7 isr empty", d, 32'h0);
    end
    wr(8'h00, 32'h0);

    // Nesting: R5 R6 R10
    irq_in = 16'h0001; idle(3);
    rd(8'h18, d); check("R2 ack in0", d, 32'h100);
    irq_in = 16'h0003; idle(3);
    check("R5 equal blocked", {31'd0, irq_line}, 32'h0);
    irq_in = 16'h0013; idle(3);
    check("R5 higher line", {31'd0, irq_line}, 32'h1);
    rd(8'h18, d); check("R5 nested ack", d, 32'h104);
    rd(8'h14, d); check("R5 isr two", d, 32'h0011);
    wr(8'h28, 32'hF); rd(8'h28, d); check("R10 frozen", d, 32'h0);
    irq_in = 16'h0003; wr(8'h1C, 32'h0);
    rd(8'h14, d); check("R6 eoi top level", d, 32'h0001);
    check("R6 still blocked", {31'd0, irq_line}, 32'h0);
    irq_in = 16'h0002; wr(8'h1C, 32'h0); idle(3);
    check("R6 reenabled", {31'd0, irq_line}, 32'h1);
    rd(8'h18, d); check("R6 ack in1", d, 32'h101);
    irq_in = '0; wr(8'h1C, 32'h0);
    wr(8'h28, 32'h3); rd(8'h28, d); check("R10 writable", d, 32'h3);
    wr(8'h28, 32'h0);

    // Empty read: R7
    rd(8'h18, d); check("R7 default", d, 32'h00F);
    rd(8'h14, d); check("R7 isr untouched", d, 32'h0);

    // Edge detection: R8
    wr(8'h04, 32'h0008);
    @(negedge clk); irq_in = 16'h0008; idle(2); irq_in = '0; idle(3);
    rd(8'h08, d); check("R8 edge latched", d, 32'h0008);
    rd(8'h18, d); check("R8 edge ack", d, 32'h103);
    rd(8'h08, d); check("R8 cleared on ack", d, 32'h0);
    wr(8'h1C, 32'h0); idle(1);
    check("R8 no line after", {31'd0, irq_line}, 32'h0);
    irq_in = 16'h0020; idle(3);
    rd(8'h08, d); check("R8 level no edge", d, 32'h0);
    irq_in = '0; idle(3);
    check("R8 level follows", {31'd0, irq_line}, 32'h0);
    wr(8'h04, 32'h0);

    // Software request: R9
    wr(8'h0C, 32'h0200);
    rd(8'h10, d); check("R9 request visible", d, 32'h0200);
    rd(8'h18, d); check("R9 sw ack", d, 32'h109);
    rd(8'h10, d); check("R9 cleared", d, 32'h0);
    wr(8'h1C, 32'h0);

    // Fast path: R11
    wr(8'h80, 32'h0);
    fiq_in = 8'h40; idle(3);
    check("R11 fast line", {30'd0, irq_line, fiq_line}, 32'h1);
    rd(8'h98, d); check("R11 fast vector", d, 32'h106);
    rd(8'h94, d); check("R11 fast isr", d, 32'h40);
    fiq_in = '0; wr(8'h9C, 32'h0);
    rd(8'h94, d); check("R11 fast eoi", d, 32'h0);
    fiq_in = 8'h0C; idle(3);
    rd(8'h98, d); check("R11/R3 fast tie", d, 32'h102);
    fiq_in = '0; wr(8'h9C, 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule